// File: doc/BRIEF.md
# Chained Expansion Slot Address Decoder

This block holds the address decode and configuration state for one card on an expansion bus where the cards are chained one behind another. An unconfigured card whose enable input from the host side is held low answers in a fixed configuration window, identified by high address byte 0xE8. Host software writes a new base address into that window one nibble at a time. When the final nibble is written, the card moves to the new base. It stops answering in the window and pulls its done output low, so the next card out in the chain can take its turn. Software can also silence a card by writing a separate offset. The card then counts as configured and hands on the chain, but it never decodes an address again.

Each card reports a match on its own decoder toward the host side. It also watches the matching report that comes in from the card further out. If both cards claim the same access while the address strobe is active, the card raises a bus error. Every output is registered, so a result appears one clock edge after the inputs that cause it.

Top module: `slotdec_top`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `doneN`, `selN` and `berrN` are high and `chipSel` is low.
- R2: An unconfigured card with `cfgInN` low matches `addrHi` = 0xE8. One edge later, `selN` is low, and `chipSel` is high if `strobe` was high.
- R3: While `cfgInN` is high, an unconfigured card matches no address and ignores configuration writes, so `doneN` stays high.
- R4: A configuration write (`strobe` and `wrStb` high inside the window) at offset 0x2 stores `dataNib` as the low nibble of the base. A write at offset 0x0 sets the base to {`dataNib`, stored low nibble} and marks the card configured. `doneN` goes low at that edge and stays low until reset.
- R5: A configured card matches only its assigned base, whatever the level of `cfgInN`. It no longer matches 0xE8.
- R6: A configuration write at offset 0xC marks the card configured without loading a base. `doneN` goes low, and from then on the card matches no address.
- R7: `selN` reflects the decoder match one edge later, whether or not `strobe` is high.
- R8: `berrN` is low one edge after a cycle in which the decoder matched, `strobe` was high and `upSelN` was low. It is high otherwise, including once `strobe` drops.
- R9: `chipSel` is high only one edge after a cycle with a match and `strobe` high.
- R10: A write with `wrStb` low, or a write at any offset other than 0x0, 0x2 or 0xC, leaves the card unconfigured.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| addrHi | input | 8 | High byte of the bus address |
| addrOfs | input | 4 | Register offset inside the configuration window |
| dataNib | input | 4 | Data nibble for configuration writes |
| strobe | input | 1 | Address strobe, active high |
| wrStb | input | 1 | Write strobe, active high |
| cfgInN | input | 1 | Configuration enable from the host-side neighbour, active low |
| upSelN | input | 1 | Match report from the card further out, active low |
| doneN | output | 1 | Configuration done toward the next card out, active low |
| selN | output | 1 | Match report toward the host-side neighbour, active low |
| chipSel | output | 1 | Local chip select, active high |
| berrN | output | 1 | Bus error, active low |

## Verification
Match, chip select and bus error are all registered from the inputs of the cycle before, so each of them is due at the first rising edge after a stimulus is applied. The configuration state and `doneN` change at that same edge, when the completing write is captured. The bench drives each stimulus on a falling edge and queues the outputs it expects for the next rising edge. A monitor samples one time unit after that rising edge and compares against the head of the queue, so every expectation is checked exactly one edge after its stimulus. Checks after reset read the outputs directly, while reset is held and in the cycle after it is released.

// File: rtl/slotdec_pkg.sv
package slotdec_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic loadLo;  // stage low part of the base
    logic loadHi;  // commit full base
  } cfgStrobe_t;
endpackage

// File: rtl/slotdec_path.sv
module slotdec_path
  import slotdec_pkg::*;
#(
  parameter int HI_W = 8,
  parameter int NIB_W = 4,
  parameter logic [HI_W-1:0] DEF_BASE = 8'hE8
) (
  input  logic             clk,
  input  logic             rst,
  input  cfgStrobe_t       stb,
  input  logic [NIB_W-1:0] dataNib,
  input  logic [HI_W-1:0]  addrHi,
  output logic             eqDefault,
  output logic             eqBase
);
  localparam int LOW_W = (HI_W > NIB_W) ? HI_W - NIB_W : 1;

  logic [HI_W-1:0] baseReg;

  generate
    if (HI_W > NIB_W) begin : g_split
      logic [LOW_W-1:0] lowStage;
      always_ff @(posedge clk) begin
        if (rst) begin
          lowStage <= '0;
          baseReg  <= DEF_BASE;
        end else begin
          if (stb.loadLo) lowStage <= LOW_W'(dataNib);
          if (stb.loadHi) baseReg  <= {dataNib, lowStage};
        end
      end
    end else begin : g_single
      always_ff @(posedge clk) begin
        if (rst) baseReg <= DEF_BASE;
        else if (stb.loadHi) baseReg <= HI_W'(dataNib);
      end
    end
  endgenerate

  assign eqDefault = (addrHi == DEF_BASE);
  assign eqBase    = (addrHi == baseReg);
endmodule

// File: rtl/slotdec_ctrl.sv
module slotdec_ctrl
  import slotdec_pkg::*;
#(
  parameter int OFS_W = 4,
  parameter logic [OFS_W-1:0] OFS_HI = 4'h0,
  parameter logic [OFS_W-1:0] OFS_LO = 4'h2,
  parameter logic [OFS_W-1:0] OFS_SHUT = 4'hC
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             eqDefault,
  input  logic             eqBase,
  input  logic [OFS_W-1:0] addrOfs,
  input  logic             strobe,
  input  logic             wrStb,
  input  logic             cfgInN,
  input  logic             upSelN,
  output cfgStrobe_t       stb,
  output logic             doneN,
  output logic             selN,
  output logic             chipSel,
  output logic             berrN
);
  logic configured, silenced;
  logic winHit, baseHit, match, cfgWrite, shutWr;
  logic matchQ, csQ, berrQ;

  assign winHit   = !configured && !cfgInN && eqDefault;
  assign baseHit  = configured && !silenced && eqBase;
  assign match    = winHit || baseHit;
  assign cfgWrite = strobe && wrStb && winHit;
  assign shutWr   = cfgWrite && (addrOfs == OFS_SHUT);

  always_comb begin
    stb.loadLo = cfgWrite && (addrOfs == OFS_LO);
    stb.loadHi = cfgWrite && (addrOfs == OFS_HI);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      configured <= 1'b0;
      silenced   <= 1'b0;
      matchQ     <= 1'b0;
      csQ        <= 1'b0;
      berrQ      <= 1'b0;
    end else begin
      if (stb.loadHi) configured <= 1'b1;
      if (shutWr) begin
        configured <= 1'b1;
        silenced   <= 1'b1;
      end
      matchQ <= match;
      csQ    <= match && strobe;
      berrQ  <= match && strobe && !upSelN;
    end
  end

  assign doneN   = !configured;
  assign selN    = !matchQ;
  assign chipSel = csQ;
  assign berrN   = !berrQ;
endmodule

// File: rtl/slotdec_top.sv
module slotdec_top
  import slotdec_pkg::*;
#(
  parameter int HI_W = 8,
  parameter int NIB_W = 4,
  parameter int OFS_W = 4,
  parameter logic [HI_W-1:0] DEF_BASE = 8'hE8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [HI_W-1:0]  addrHi,
  input  logic [OFS_W-1:0] addrOfs,
  input  logic [NIB_W-1:0] dataNib,
  input  logic             strobe,
  input  logic             wrStb,
  input  logic             cfgInN,
  input  logic             upSelN,
  output logic             doneN,
  output logic             selN,
  output logic             chipSel,
  output logic             berrN
);
  cfgStrobe_t stb;
  logic eqDefault, eqBase;

  slotdec_path #(.HI_W(HI_W), .NIB_W(NIB_W), .DEF_BASE(DEF_BASE)) u_path (
    .clk(clk), .rst(rst), .stb(stb), .dataNib(dataNib), .addrHi(addrHi),
    .eqDefault(eqDefault), .eqBase(eqBase)
  );

  slotdec_ctrl #(.OFS_W(OFS_W)) u_ctrl (
    .clk(clk), .rst(rst), .eqDefault(eqDefault), .eqBase(eqBase),
    .addrOfs(addrOfs), .strobe(strobe), .wrStb(wrStb), .cfgInN(cfgInN),
    .upSelN(upSelN), .stb(stb), .doneN(doneN), .selN(selN),
    .chipSel(chipSel), .berrN(berrN)
  );
endmodule

// File: rtl/slotdec_chk.sv
module slotdec_chk (
  input logic clk,
  input logic rst,
  input logic strobe,
  input logic cfgInN,
  input logic upSelN,
  input logic doneN,
  input logic selN,
  input logic chipSel,
  input logic berrN
);
  // R4: once configured, done stays asserted
  assert_done_sticky_R4: assert property (@(posedge clk) disable iff (rst)
    !doneN |=> !doneN);

  // R3: no configuration while the chain input is inactive
  assert_hold_off_R3: assert property (@(posedge clk) disable iff (rst)
    (cfgInN && doneN) |=> doneN);

  // R9: chip select needs the strobe in the cycle before
  assert_cs_strobe_R9: assert property (@(posedge clk) disable iff (rst)
    !strobe |=> !chipSel);

  // R8: bus error only after a strobed cycle with the far card selecting
  assert_berr_cause_R8: assert property (@(posedge clk) disable iff (rst)
    (strobe && !berrN) |-> $past(strobe && !upSelN));

  // R7: bus error and chip select imply own match report
  assert_sel_cover_R7: assert property (@(posedge clk) disable iff (rst)
    (!berrN || chipSel) |-> !selN);
endmodule

bind slotdec_top slotdec_chk u_chk (
  .clk(clk), .rst(rst), .strobe(strobe), .cfgInN(cfgInN), .upSelN(upSelN),
  .doneN(doneN), .selN(selN), .chipSel(chipSel), .berrN(berrN)
);

// File: tb/slotdec_top_tb.sv
module slotdec_top_tb;
  localparam int PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0] addrHi = '0;
  logic [3:0] addrOfs = '0;
  logic [3:0] dataNib = '0;
  logic strobe = 1'b0, wrStb = 1'b0, cfgInN = 1'b1, upSelN = 1'b1;
  logic doneN, selN, chipSel, berrN;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  typedef struct {
    logic m, c, b, d;
    string tag;
  } exp_t;
  exp_t q[$];

  always #(PERIOD/2) clk = ~clk;

  slotdec_top u_dut (
    .clk(clk), .rst(rst), .addrHi(addrHi), .addrOfs(addrOfs),
    .dataNib(dataNib), .strobe(strobe), .wrStb(wrStb), .cfgInN(cfgInN),
    .upSelN(upSelN), .doneN(doneN), .selN(selN), .chipSel(chipSel),
    .berrN(berrN)
  );

  task automatic compare(input logic m, c, b, d, input string tag);
    checks++;
    if ({selN, chipSel, berrN, doneN} !== {~m, c, ~b, ~d}) begin
      failures++;
      $display("FAIL %s: selN/chipSel/berrN/doneN actual=%b%b%b%b expected=%b%b%b%b",
               tag, selN, chipSel, berrN, doneN, ~m, c, ~b, ~d);
    end
  endtask

  // monitor: results are due one edge after each stimulus
  always begin
    @(posedge clk);
    #1;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      compare(e.m, e.c, e.b, e.d, e.tag);
    end
  end

  // driver: one bus cycle, expected outputs (match, cs, berr, done)
  task automatic step(input logic [7:0] a, input logic [3:0] o, input logic [3:0] dn,
                      input logic s, w, ci, us,
                      input logic em, ec, eb, ed, input string tag);
    exp_t e;
    @(negedge clk);
    addrHi = a; addrOfs = o; dataNib = dn;
    strobe = s; wrStb = w; cfgInN = ci; upSelN = us;
    e.m = em; e.c = ec; e.b = eb; e.d = ed; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1; strobe = 1'b0; wrStb = 1'b0; cfgInN = 1'b1; upSelN = 1'b1;
    addrHi = '0;
    @(posedge clk); #2;
    compare(1'b0, 1'b0, 1'b0, 1'b0, "R1 in reset");
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk); #2;
    compare(1'b0, 1'b0, 1'b0, 1'b0, "R1 after reset");
  endtask

  initial begin
    doReset();
    // R3: chain input inactive, no match and writes ignored
    step(8'hE8, 4'h1, 4'h0, 1, 0, 1, 1, 0, 0, 0, 0, "R3 no match");
    step(8'hE8, 4'h0, 4'h5, 1, 1, 1, 1, 0, 0, 0, 0, "R3 write ignored");
    step(8'h00, 4'h0, 4'h0, 0, 0, 1, 1, 0, 0, 0, 0, "R3 still unconfigured");
    // R2: window decode
    step(8'hE8, 4'h1, 4'h0, 1, 0, 0, 1, 1, 1, 0, 0, "R2 window hit");
    step(8'h20, 4'h1, 4'h0, 1, 0, 0, 1, 0, 0, 0, 0, "R2 outside window");
    // R7 and R9: match without strobe
    step(8'hE8, 4'h1, 4'h0, 0, 0, 0, 1, 1, 0, 0, 0, "R9 R7 match no strobe");
    // R8: conflict with far card
    step(8'hE8, 4'h1, 4'h0, 1, 0, 0, 0, 1, 1, 1, 0, "R8 conflict");
    step(8'hE8, 4'h1, 4'h0, 0, 0, 0, 0, 1, 0, 0, 0, "R8 released without strobe");
    step(8'h20, 4'h1, 4'h0, 1, 0, 0, 0, 0, 0, 0, 0, "R8 no own match");
    // R10: writes that do not configure
    step(8'hE8, 4'h0, 4'h9, 1, 0, 0, 1, 1, 1, 0, 0, "R10 no write strobe");
    step(8'hE8, 4'h5, 4'h9, 1, 1, 0, 1, 1, 1, 0, 0, "R10 other offset");
    step(8'h00, 4'h0, 4'h0, 0, 0, 0, 1, 0, 0, 0, 0, "R10 still unconfigured");
    // R4: load base 0xA4
    step(8'hE8, 4'h2, 4'h4, 1, 1, 0, 1, 1, 1, 0, 0, "R4 low nibble");
    step(8'hE8, 4'h0, 4'hA, 1, 1, 0, 1, 1, 1, 0, 1, "R4 commit base");
    step(8'h00, 4'h0, 4'h0, 0, 0, 0, 1, 0, 0, 0, 1, "R4 done held");
    // R5: responds only at new base
    step(8'hE8, 4'h1, 4'h0, 1, 0, 0, 1, 0, 0, 0, 1, "R5 window dropped");
    step(8'hA4, 4'h1, 4'h0, 1, 0, 0, 1, 1, 1, 0, 1, "R5 base hit");
    step(8'hA4, 4'h1, 4'h0, 1, 0, 1, 1, 1, 1, 0, 1, "R5 base hit cfgIn high");
    step(8'hA5, 4'h1, 4'h0, 1, 0, 0, 1, 0, 0, 0, 1, "R5 near miss");
    step(8'hA4, 4'h1, 4'h0, 1, 0, 0, 0, 1, 1, 1, 1, "R8 conflict at base");
    // R6: silence after fresh reset
    doReset();
    step(8'hE8, 4'hC, 4'h0, 1, 1, 0, 1, 1, 1, 0, 1, "R6 shut write");
    step(8'hE8, 4'h1, 4'h0, 1, 0, 0, 1, 0, 0, 0, 1, "R6 no window");
    step(8'hE8, 4'h0, 4'h3, 1, 1, 0, 0, 0, 0, 0, 1, "R6 later write ignored");
    step(8'h03, 4'h1, 4'h0, 1, 0, 0, 0, 0, 0, 0, 1, "R6 no base");
    step(8'h00, 4'h0, 4'h0, 0, 0, 0, 1, 0, 0, 0, 1, "R6 idle");
    @(posedge clk); #3;
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(PERIOD * 20000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule